// File: doc/BRIEF.md
# Remote Memory Request Engine

This block serves one word-sized load or store at a time for a memory bus whose backing store sits on a remote server. A request from the bus is latched, formatted into a fixed 16-byte request datagram and streamed byte by byte into a transmit interface that feeds a UDP offload controller. The engine then watches a receive byte stream for the matching reply. A load reply returns the word. A store reply confirms the write. Either one ends the access with a single-cycle completion pulse.

A reply can also tell the engine to move elsewhere. In that case it carries a new IPv4 destination and port, which the engine loads into its destination registers before it sends the same request again. If no usable reply arrives within a configurable number of clock cycles, the request is sent again unchanged. After reset the destination registers hold fixed values set by parameters. The controller programs its socket from these registers.

Datagram layout, used in both directions, with multi-byte fields sent most significant byte first:

| Bytes | Content |
|---|---|
| 0–3 | word address |
| 4–5 | transfer length |
| 6 | byte-enable mask (the upper nibble is zero) |
| 7 | flags: bit0 store, bit1 read-only region, bit2 move to a new destination |
| 8–15 | data |

Top module: `remote_mem_engine`

## Requirements
- R1: After reset, busy, tx_valid and done are 0, and dest_ip and dest_port equal the parameters INIT_IP and INIT_PORT.
- R2: A request is accepted only when req_valid is high while busy is 0. busy rises in the next cycle. A req_valid pulse while busy is 1 is ignored: no extra datagram is sent, and the returned word belongs to the first request.
- R3: Each request is sent as exactly 16 bytes with tx_last on byte 15. Bytes 0–3 hold the address MSB first, bytes 4–5 hold the length 0x0004, and bytes 12–15 are zero.
- R4: For a store, byte 7 (flags) is 0x01, byte 6 is the 4-bit write mask, and bytes 8–11 hold the write data MSB first. For a load, bytes 6–11 are zero.
- R5: A 16-byte reply whose address matches and whose flags bit2 is clear raises done for the cycle that follows the second rising edge after the final reply byte is taken. In that cycle rdata equals reply bytes 8–11, MSB first.
- R6: In the done cycle, ro_flag equals bit1 of the reply flags, so a region the server marks read-only, such as addresses 0xC000 to 0xFFFF, is reported to the bus.
- R7: A matching reply with flags bit2 set loads dest_ip from reply bytes 8–11 and dest_port from bytes 12–13. One cycle later the identical 16-byte request is sent again, and done stays 0.
- R8: If TIMEOUT_CYCLES cycles pass after the last request byte without a usable reply, the identical request is sent again. tx_valid is low for exactly TIMEOUT_CYCLES cycles between the two datagrams.
- R9: A reply whose address field differs from the outstanding request is discarded: done stays 0, and a later matching reply still completes the access.
- R10: A reply whose rx_last arrives on any byte other than the 16th is discarded without completing the access.
- R11: While tx_valid is 1 and tx_ready is 0, tx_data and tx_last hold their values and tx_valid stays 1.
- R12: done is high for one cycle per completed access, and busy is 0 in the cycle after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus requests a remote access |
| req_addr | input | 32 | Word address of the access |
| req_write | input | 1 | 1 = store, 0 = load |
| req_wmask | input | 4 | Byte enables for a store |
| req_wdata | input | 32 | Store data |
| busy | output | 1 | An access is in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Loaded word, valid with done |
| ro_flag | output | 1 | Read-only indication from the reply, valid with done |
| tx_valid | output | 1 | Request byte available |
| tx_ready | input | 1 | Controller takes the byte |
| tx_data | output | 8 | Request byte |
| tx_last | output | 1 | Final byte of the datagram |
| rx_valid | input | 1 | Reply byte available |
| rx_data | input | 8 | Reply byte |
| rx_last | input | 1 | Final byte of the reply datagram |
| dest_ip | output | 32 | Current destination IPv4 address |
| dest_port | output | 16 | Current destination port |

## Verification
Completion is checked at exact cycle offsets. The bench drives the final reply byte on a falling edge and then samples once per falling edge. done must be low one sample later, high at the second sample and low again at the third, and rdata and ro_flag are read in the middle sample. After a redirect the new datagram must start after exactly one idle sample. After a lost reply the gap must be exactly TIMEOUT_CYCLES idle samples. A request byte counts as sent only on a sample that sees tx_valid and tx_ready together, so the byte checks follow the handshake rather than the wall clock.

// File: rtl/rme_pkg.sv
package rme_pkg;
    localparam int FRAME_BYTES = 16;
    localparam int IDX_W       = $clog2(FRAME_BYTES);
    localparam logic [15:0] XFER_LEN = 16'd4;
    localparam int FL_STORE    = 0;
    localparam int FL_RO       = 1;
    localparam int FL_MOVE     = 2;

    typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_WAIT} eng_state_e;

    typedef struct packed {
        logic [31:0] addr;
        logic        write;
        logic [3:0]  wmask;
        logic [31:0] wdata;
    } mem_req_t;

    typedef struct packed {
        logic [31:0] addr;
        logic [15:0] len;
        logic [7:0]  mask;
        logic [7:0]  flags;
        logic [63:0] data;
    } reply_t;
endpackage

// File: rtl/rme_tx_frame.sv
module rme_tx_frame
    import rme_pkg::*;
(
    input  mem_req_t         req,
    input  logic [IDX_W-1:0] idx,
    output logic [7:0]       byte_o
);
    logic [7:0] mask_b;
    logic [7:0] flag_b;
    logic [31:0] data_w;

    always_comb begin
        mask_b = req.write ? {4'h0, req.wmask} : 8'h00;
        flag_b = 8'h00;
        flag_b[FL_STORE] = req.write;
        data_w = req.write ? req.wdata : 32'h0;
        case (idx)
            4'd0:    byte_o = req.addr[31:24];
            4'd1:    byte_o = req.addr[23:16];
            4'd2:    byte_o = req.addr[15:8];
            4'd3:    byte_o = req.addr[7:0];
            4'd4:    byte_o = XFER_LEN[15:8];
            4'd5:    byte_o = XFER_LEN[7:0];
            4'd6:    byte_o = mask_b;
            4'd7:    byte_o = flag_b;
            4'd8:    byte_o = data_w[31:24];
            4'd9:    byte_o = data_w[23:16];
            4'd10:   byte_o = data_w[15:8];
            4'd11:   byte_o = data_w[7:0];
            default: byte_o = 8'h00;
        endcase
    end
endmodule

// File: rtl/rme_rx_parse.sv
module rme_rx_parse
    import rme_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    input  logic       rx_last,
    output logic       frame_ok,
    output reply_t     reply
);
    localparam int CNT_W = $clog2(FRAME_BYTES + 1);

    typedef struct packed {
        logic [FRAME_BYTES*8-1:0] shreg;
        logic [CNT_W-1:0]         cnt;
        logic                     ok;
    } rx_st_t;

    rx_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.ok = 1'b0;
        if (rx_valid) begin
            st_d.shreg = {st_q.shreg[FRAME_BYTES*8-9:0], rx_data};
            if (rx_last) begin
                st_d.ok  = (st_q.cnt == CNT_W'(FRAME_BYTES - 1));
                st_d.cnt = '0;
            end else if (st_q.cnt != CNT_W'(FRAME_BYTES)) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign frame_ok = st_q.ok;
    assign reply    = reply_t'(st_q.shreg);
endmodule

// File: rtl/rme_timer.sv
module rme_timer #(
    parameter int TIMEOUT_CYCLES = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CW = (TIMEOUT_CYCLES > 1) ? $clog2(TIMEOUT_CYCLES) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d   = run ? cnt_q + 1'b1 : '0;
        expired = run && (cnt_q == CW'(TIMEOUT_CYCLES - 1));
        if (expired) cnt_d = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/remote_mem_engine.sv
module remote_mem_engine
    import rme_pkg::*;
#(
    parameter int          TIMEOUT_CYCLES = 50000,
    parameter logic [31:0] INIT_IP        = 32'hC0A8_0164,
    parameter logic [15:0] INIT_PORT      = 16'h20D0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic [31:0] req_addr,
    input  logic        req_write,
    input  logic [3:0]  req_wmask,
    input  logic [31:0] req_wdata,
    output logic        busy,
    output logic        done,
    output logic [31:0] rdata,
    output logic        ro_flag,
    output logic        tx_valid,
    input  logic        tx_ready,
    output logic [7:0]  tx_data,
    output logic        tx_last,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    input  logic        rx_last,
    output logic [31:0] dest_ip,
    output logic [15:0] dest_port
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BYTES - 1);

    typedef struct packed {
        eng_state_e       state;
        mem_req_t         req;
        logic [IDX_W-1:0] idx;
        logic [31:0]      ip;
        logic [15:0]      port;
        logic             done;
        logic [31:0]      rdata;
        logic             ro;
    } eng_t;

    eng_t   s_d, s_q;
    logic   frame_ok;
    reply_t reply;
    logic   expired;
    logic   match;
    logic   unused_reply_bits;

    rme_tx_frame u_tx (
        .req    (s_q.req),
        .idx    (s_q.idx),
        .byte_o (tx_data)
    );

    rme_rx_parse u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_valid (rx_valid),
        .rx_data  (rx_data),
        .rx_last  (rx_last),
        .frame_ok (frame_ok),
        .reply    (reply)
    );

    rme_timer #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (s_q.state == ST_WAIT),
        .expired (expired)
    );

    assign match = frame_ok && (reply.addr == s_q.req.addr);
    assign unused_reply_bits = ^{reply.len, reply.mask, reply.data[15:0],
                                 reply.flags[7:3], reply.flags[0]};

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        case (s_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    s_d.req   = '{addr: req_addr, write: req_write,
                                  wmask: req_wmask, wdata: req_wdata};
                    s_d.idx   = '0;
                    s_d.state = ST_SEND;
                end
            end
            ST_SEND: begin
                if (tx_ready) begin
                    if (s_q.idx == LAST_IDX) s_d.state = ST_WAIT;
                    else                     s_d.idx   = s_q.idx + 1'b1;
                end
            end
            ST_WAIT: begin
                if (match && reply.flags[FL_MOVE]) begin
                    s_d.ip    = reply.data[63:32];
                    s_d.port  = reply.data[31:16];
                    s_d.idx   = '0;
                    s_d.state = ST_SEND;
                end else if (match) begin
                    s_d.done  = 1'b1;
                    s_d.rdata = reply.data[63:32];
                    s_d.ro    = reply.flags[FL_RO];
                    s_d.state = ST_IDLE;
                end else if (expired) begin
                    s_d.idx   = '0;
                    s_d.state = ST_SEND;
                end
            end
            default: s_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.state <= ST_IDLE;
            s_q.ip    <= INIT_IP;
            s_q.port  <= INIT_PORT;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy      = (s_q.state != ST_IDLE);
    assign done      = s_q.done;
    assign rdata     = s_q.rdata;
    assign ro_flag   = s_q.ro;
    assign tx_valid  = (s_q.state == ST_SEND);
    assign tx_last   = tx_valid && (s_q.idx == LAST_IDX);
    assign dest_ip   = s_q.ip;
    assign dest_port = s_q.port;
endmodule

// File: rtl/rme_checker.sv
module rme_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        done,
    input logic        tx_valid,
    input logic        tx_ready,
    input logic [7:0]  tx_data,
    input logic        tx_last,
    input logic [31:0] dest_ip,
    input logic [15:0] dest_port
);
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R12
    AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R12
    AST_TX_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> busy); // R2
    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last))); // R11
    AST_DEST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> ($stable(dest_ip) && $stable(dest_port))); // R7
    AST_NO_DONE_SENDING: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> !done); // R5
endmodule

bind remote_mem_engine rme_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_data   (tx_data),
    .tx_last   (tx_last),
    .dest_ip   (dest_ip),
    .dest_port (dest_port)
);

// File: tb/remote_mem_engine_tb_top.sv
module remote_mem_engine_tb_top;
    localparam int          TMO   = 80;
    localparam logic [31:0] IP0   = 32'hC0A8_0164;
    localparam logic [15:0] PORT0 = 16'h20D0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [3:0]  req_wmask = '0;
    logic [31:0] req_wdata = '0;
    logic        busy, done, ro_flag, tx_valid, tx_last;
    logic [31:0] rdata, dest_ip;
    logic [15:0] dest_port;
    logic [7:0]  tx_data;
    logic        tx_ready = 1'b1;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_last = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] frm [16];
    logic [7:0] exp_f [16];
    int gap;

    always #10 clk = ~clk;

    remote_mem_engine #(.TIMEOUT_CYCLES(TMO), .INIT_IP(IP0), .INIT_PORT(PORT0)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .req_wmask(req_wmask), .req_wdata(req_wdata),
        .busy(busy), .done(done), .rdata(rdata), .ro_flag(ro_flag),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
        .dest_ip(dest_ip), .dest_port(dest_port)
    );

    task automatic check(input string rq, input string what, input logic [63:0] act, input logic [63:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, expv);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic build_exp(input logic [31:0] a, input logic w, input logic [3:0] m, input logic [31:0] d);
        for (int i = 0; i < 16; i++) exp_f[i] = 8'h00;
        exp_f[0] = a[31:24]; exp_f[1] = a[23:16]; exp_f[2] = a[15:8]; exp_f[3] = a[7:0];
        exp_f[5] = 8'h04;
        if (w) begin
            exp_f[6] = {4'h0, m}; exp_f[7] = 8'h01;
            exp_f[8] = d[31:24]; exp_f[9] = d[23:16]; exp_f[10] = d[15:8]; exp_f[11] = d[7:0];
        end
    endtask

    task automatic issue(input logic [31:0] a, input logic w, input logic [3:0] m, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = w; req_wmask = m; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        check("R2", "busy after accept", busy, 1);
    endtask

    // collects one datagram; stall_at >= 0 drops tx_ready for 3 cycles at that byte
    task automatic capture(input int stall_at);
        int k;
        logic [7:0] held;
        k = 0; gap = 0;
        while (!tx_valid && gap < 4 * TMO) begin
            gap++;
            @(negedge clk);
        end
        while (k < 16) begin
            if (k == stall_at && tx_ready) begin
                tx_ready = 1'b0;
                held = tx_data;
                for (int s = 0; s < 3; s++) begin
                    @(negedge clk);
                    check("R11", "tx_valid held", tx_valid, 1);
                    check("R11", "tx_data held", tx_data, held);
                end
                tx_ready = 1'b1;
            end
            if (tx_valid && tx_ready) begin
                frm[k] = tx_data;
                check("R3", "tx_last position", tx_last, (k == 15));
                k++;
            end
            @(negedge clk);
        end
    endtask

    task automatic cmp_frame(input string rq);
        for (int i = 0; i < 16; i++) check(rq, $sformatf("request byte %0d", i), frm[i], exp_f[i]);
    endtask

    task automatic reply(input logic [31:0] a, input logic [7:0] fl, input logic [63:0] d, input int nbytes);
        logic [7:0] b [16];
        b[0] = a[31:24]; b[1] = a[23:16]; b[2] = a[15:8]; b[3] = a[7:0];
        b[4] = 8'h00; b[5] = 8'h04; b[6] = 8'h00; b[7] = fl;
        for (int i = 0; i < 8; i++) b[8 + i] = d[63 - 8*i -: 8];
        for (int i = 0; i < nbytes; i++) begin
            rx_valid = 1'b1; rx_data = b[i]; rx_last = (i == nbytes - 1);
            @(negedge clk);
        end
        rx_valid = 1'b0; rx_last = 1'b0;
    endtask

    task automatic expect_done(input string rq, input logic [31:0] rd, input logic ro);
        check(rq, "done not yet", done, 0);
        @(negedge clk);
        check(rq, "done pulse", done, 1);
        check(rq, "rdata", rdata, rd);
        check("R6", "ro_flag", ro_flag, ro);
        @(negedge clk);
        check("R12", "done single cycle", done, 0);
        check("R12", "idle after done", busy, 0);
    endtask

    task automatic t_reset();
        check("R1", "busy", busy, 0);
        check("R1", "tx_valid", tx_valid, 0);
        check("R1", "done", done, 0);
        check("R1", "dest_ip", dest_ip, IP0);
        check("R1", "dest_port", dest_port, PORT0);
    endtask

    task automatic t_load();
        issue(32'h0001_2340, 1'b0, 4'h0, 32'h0);
        build_exp(32'h0001_2340, 1'b0, 4'h0, 32'h0);
        capture(-1);
        cmp_frame("R3");
        reply(32'h0001_2340, 8'h00, 64'hDEAD_BEEF_0000_0000, 16);
        expect_done("R5", 32'hDEAD_BEEF, 1'b0);
    endtask

    task automatic t_store_ro();
        issue(32'h0000_C008, 1'b1, 4'h5, 32'h1122_3344);
        build_exp(32'h0000_C008, 1'b1, 4'h5, 32'h1122_3344);
        capture(5);
        cmp_frame("R4");
        reply(32'h0000_C008, 8'h03, 64'h0, 16);
        expect_done("R6", 32'h0, 1'b1);
    endtask

    task automatic t_busy_ignore();
        issue(32'h0000_0100, 1'b0, 4'h0, 32'h0);
        capture(-1);
        @(negedge clk);
        req_valid = 1'b1; req_addr = 32'h0000_0200;
        @(negedge clk);
        req_valid = 1'b0;
        reply(32'h0000_0100, 8'h00, 64'hCAFE_0001_0000_0000, 16);
        expect_done("R2", 32'hCAFE_0001, 1'b0);
        repeat (5) begin
            check("R2", "no extra datagram", tx_valid, 0);
            @(negedge clk);
        end
    endtask

    task automatic t_redirect();
        issue(32'h0000_0400, 1'b0, 4'h0, 32'h0);
        build_exp(32'h0000_0400, 1'b0, 4'h0, 32'h0);
        capture(-1);
        reply(32'h0000_0400, 8'h04, 64'h0A00_0005_1F90_0000, 16);
        check("R7", "no done on move", done, 0);
        capture(-1);
        check("R7", "resend gap", gap, 1);
        check("R7", "dest_ip", dest_ip, 32'h0A00_0005);
        check("R7", "dest_port", dest_port, 16'h1F90);
        cmp_frame("R7");
        reply(32'h0000_0400, 8'h00, 64'h0BAD_F00D_0000_0000, 16);
        expect_done("R5", 32'h0BAD_F00D, 1'b0);
    endtask

    task automatic t_timeout();
        issue(32'h0000_0800, 1'b1, 4'hF, 32'hA5A5_5A5A);
        build_exp(32'h0000_0800, 1'b1, 4'hF, 32'hA5A5_5A5A);
        capture(-1);
        capture(-1);
        check("R8", "timeout gap", gap, TMO);
        cmp_frame("R8");
        reply(32'h0000_0800, 8'h01, 64'h0, 16);
        expect_done("R8", 32'h0, 1'b0);
    endtask

    task automatic t_mismatch();
        issue(32'h0000_1000, 1'b0, 4'h0, 32'h0);
        capture(-1);
        reply(32'h0000_1004, 8'h00, 64'h1111_1111_0000_0000, 16);
        repeat (3) begin
            check("R9", "mismatch ignored", done, 0);
            @(negedge clk);
        end
        reply(32'h0000_1000, 8'h00, 64'h2222_2222_0000_0000, 16);
        expect_done("R9", 32'h2222_2222, 1'b0);
    endtask

    task automatic t_short();
        issue(32'h0000_2000, 1'b0, 4'h0, 32'h0);
        capture(-1);
        reply(32'h0000_2000, 8'h00, 64'h3333_3333_0000_0000, 10);
        repeat (3) begin
            check("R10", "short frame ignored", done, 0);
            @(negedge clk);
        end
        check("R10", "still busy", busy, 1);
        reply(32'h0000_2000, 8'h00, 64'h4444_4444_0000_0000, 16);
        expect_done("R10", 32'h4444_4444, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load();
        t_store_ro();
        t_busy_ignore();
        t_redirect();
        t_timeout();
        t_mismatch();
        t_short();
        repeat (3) @(negedge clk);
        summary();
        $finish;
    end
endmodule